// File: doc/BRIEF.md
# Programmable Soft Decision Slicer

This block turns a stream of signed in-phase and quadrature samples into 3-bit soft decisions for a downstream decoder. Each soft decision holds a sign bit and a 2-bit confidence level. The level is set by where the sample magnitude falls against three thresholds. The thresholds are the single programmed threshold multiplied by one, two and three. A single threshold setting therefore spaces all decision regions evenly. The threshold is a 7-bit unsigned fraction. Its most significant bit weighs one half and its least significant bit weighs 2^-7. Inputs are 10-bit two's complement fractions, so one input LSB weighs 2^-9 and one threshold LSB equals four input LSBs.

A format select can be changed at run time. It picks sign/magnitude or two's complement coding of the soft output. The setting applies to each sample as that sample is accepted. Both lanes are registered with one clock of latency. An output valid flag follows the input strobe. The threshold input is used as applied, with no storage inside the block. Because the input magnitude never exceeds about 1.0, a threshold above about one third makes the top level unreachable.

Top module: `soft_slicer`

## Requirements
- R1: While reset is asserted and after it is released, until the first accepted sample, `out_valid` is 0 and both soft outputs are 0.
- R2: `out_valid` is 1 in the cycle after a cycle in which `in_valid` is 1, and 0 in the cycle after a cycle in which it is 0, including for back-to-back samples.
- R3: With T = 4 x `cfg_thresh` in input LSBs, the level is 0 for |x| < T, 1 for T <= |x| < 2T, 2 for 2T <= |x| < 3T, and 3 for |x| >= 3T.
- R4: A magnitude exactly equal to T, 2T or 3T takes the higher level. With a threshold of 0, every sample gets level 3.
- R5: The input code 10'h200 (-1.0) is treated as negative with magnitude 511, the full-scale value.
- R6: With `cfg_twos` = 0, bit 2 of a soft output is 1 for a negative sample and 0 for zero or a positive one, and bits 1:0 hold the level.
- R7: With `cfg_twos` = 1, a non-negative sample of level L gives +L and a negative sample of level L gives -(L+1), both as 3-bit two's complement. For example, level 3 negative gives 3'b100.
- R8: 2T and 3T never wrap. With `cfg_thresh` = 127, T = 508, so a magnitude of 511 gives level 1 and 507 gives level 0.
- R9: When `in_valid` is 0, both soft outputs keep their last values.
- R10: The I and Q lanes are sliced independently with the shared threshold and format.
- R11: A change of `cfg_twos` between two consecutive samples applies to the second sample only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample strobe for `in_i` and `in_q` |
| in_i | input | 10 | In-phase sample, two's complement fraction |
| in_q | input | 10 | Quadrature sample, two's complement fraction |
| cfg_thresh | input | 7 | Unsigned fractional base threshold, weights 2^-1 down to 2^-7 |
| cfg_twos | input | 1 | Output format: 0 sign/magnitude, 1 two's complement |
| out_valid | output | 1 | Soft outputs updated this cycle |
| out_i | output | 3 | In-phase soft decision |
| out_q | output | 3 | Quadrature soft decision |

## Verification
The slicer is driven with magnitudes placed one LSB below and exactly on each of T, 2T and 3T, in both signs. This separates a strict comparison from an inclusive one and shows an off-by-one in threshold scaling. The same points are replayed in two's complement mode, where a missing -(L+1) step shows up on negative samples only. The -1.0 code and the largest threshold both stress the magnitude and threshold widths. Opposite-signed values on I and Q, idle gaps, and a format flip between back-to-back samples show lanes crossing, outputs that fail to hold, and format changes that are applied to the wrong sample.

// File: rtl/soft_slicer_pkg.sv
package soft_slicer_pkg;

  // confidence level width and resulting soft code width
  localparam int LVL_W  = 2;
  localparam int CODE_W = LVL_W + 1;

  // lane indices
  localparam int LANE_I   = 0;
  localparam int LANE_Q   = 1;
  localparam int NUM_LANE = 2;

  typedef enum logic {
    FMT_SIGN_MAG = 1'b0,
    FMT_TWOS     = 1'b1
  } soft_fmt_e;

  typedef logic [LVL_W-1:0]  level_t;
  typedef logic [CODE_W-1:0] code_t;

endpackage

// File: rtl/ss_reset_sync.sv
module ss_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/ss_magnitude.sv
module ss_magnitude #(
  parameter int DATA_W = 10,
  localparam int MAG_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] sample,
  output logic              neg,
  output logic [MAG_W-1:0]  mag
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] negated;

  always_comb begin
    neg     = sample[DATA_W-1];
    negated = ~sample + DATA_W'(1);
    if (sample == MOST_NEG) begin
      // -1.0 has no positive twin: pin it to full scale
      mag = '1;
    end else if (neg) begin
      mag = negated[MAG_W-1:0];
    end else begin
      mag = sample[MAG_W-1:0];
    end
  end

endmodule

// File: rtl/ss_thresh_gen.sv
module ss_thresh_gen #(
  parameter int TH_W  = 7,
  parameter int MAG_W = 9,
  localparam int CMP_W = MAG_W + 2
) (
  input  logic [TH_W-1:0]  thresh,
  output logic [CMP_W-1:0] t1,
  output logic [CMP_W-1:0] t2,
  output logic [CMP_W-1:0] t3
);

  logic [CMP_W-1:0] base;

  // align the threshold LSB with the magnitude LSB
  generate
    if (MAG_W >= TH_W) begin : g_up
      localparam int SH = MAG_W - TH_W;
      assign base = CMP_W'(thresh) << SH;
    end else begin : g_down
      localparam int SH = TH_W - MAG_W;
      assign base = CMP_W'(thresh >> SH);
    end
  endgenerate

  // two spare bits above the magnitude keep 3x from wrapping
  always_comb begin
    t1 = base;
    t2 = base << 1;
    t3 = base + (base << 1);
  end

endmodule

// File: rtl/ss_level_cmp.sv
module ss_level_cmp
  import soft_slicer_pkg::*;
#(
  parameter int MAG_W = 9,
  localparam int CMP_W = MAG_W + 2
) (
  input  logic [MAG_W-1:0] mag,
  input  logic [CMP_W-1:0] t1,
  input  logic [CMP_W-1:0] t2,
  input  logic [CMP_W-1:0] t3,
  output level_t           level
);

  logic [CMP_W-1:0] mag_ext;
  logic             ge1, ge2, ge3;

  always_comb begin
    mag_ext = CMP_W'(mag);
    ge1     = (mag_ext >= t1);
    ge2     = (mag_ext >= t2);
    ge3     = (mag_ext >= t3);
    if (ge3) begin
      level = 2'd3;
    end else if (ge2) begin
      level = 2'd2;
    end else if (ge1) begin
      level = 2'd1;
    end else begin
      level = 2'd0;
    end
  end

endmodule

// File: rtl/ss_encode.sv
module ss_encode
  import soft_slicer_pkg::*;
(
  input  logic      neg,
  input  level_t    level,
  input  soft_fmt_e fmt,
  output code_t     code
);

  always_comb begin
    unique case (fmt)
      FMT_TWOS: begin
        // -(L+1) equals the bitwise inverse of L with the sign set
        if (neg) code = {1'b1, ~level};
        else     code = {1'b0, level};
      end
      default: code = {neg, level};
    endcase
  end

endmodule

// File: rtl/soft_slicer.sv
module soft_slicer
  import soft_slicer_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int TH_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic [TH_W-1:0]   cfg_thresh,
  input  logic              cfg_twos,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_i,
  output logic [CODE_W-1:0] out_q
);

  localparam int MAG_W = DATA_W - 1;
  localparam int CMP_W = MAG_W + 2;

  logic             rst_sync_n;
  logic [CMP_W-1:0] th1, th2, th3;
  soft_fmt_e        fmt;

  logic [DATA_W-1:0] lane_in   [NUM_LANE];
  logic              lane_neg  [NUM_LANE];
  logic [MAG_W-1:0]  lane_mag  [NUM_LANE];
  level_t            lane_lvl  [NUM_LANE];
  code_t             lane_code [NUM_LANE];
  code_t             code_d    [NUM_LANE];
  code_t             code_q    [NUM_LANE];
  logic              valid_d;
  logic              valid_q;

  ss_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ss_thresh_gen #(.TH_W(TH_W), .MAG_W(MAG_W)) u_thr (
    .thresh (cfg_thresh),
    .t1     (th1),
    .t2     (th2),
    .t3     (th3)
  );

  assign fmt = soft_fmt_e'(cfg_twos);
  assign lane_in[LANE_I] = in_i;
  assign lane_in[LANE_Q] = in_q;

  generate
    for (genvar k = 0; k < NUM_LANE; k++) begin : g_lane
      ss_magnitude #(.DATA_W(DATA_W)) u_mag (
        .sample (lane_in[k]),
        .neg    (lane_neg[k]),
        .mag    (lane_mag[k])
      );

      ss_level_cmp #(.MAG_W(MAG_W)) u_cmp (
        .mag   (lane_mag[k]),
        .t1    (th1),
        .t2    (th2),
        .t3    (th3),
        .level (lane_lvl[k])
      );

      ss_encode u_enc (
        .neg   (lane_neg[k]),
        .level (lane_lvl[k]),
        .fmt   (fmt),
        .code  (lane_code[k])
      );

      // next state: load on strobe, otherwise hold
      always_comb begin
        code_d[k] = in_valid ? lane_code[k] : code_q[k];
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          code_q[k] <= '0;
        end else if (in_valid) begin
          code_q[k] <= code_d[k];
        end
      end

      // R5: a negative sample always has a nonzero magnitude
      p_neg_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (in_valid && lane_in[k][DATA_W-1]) |-> (lane_mag[k] != '0));

      // R3: zero magnitude against a nonzero threshold is level 0
      p_zero_level_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (in_valid && lane_mag[k] == '0 && th1 != '0) |-> (lane_lvl[k] == 2'd0));
    end
  endgenerate

  always_comb begin
    valid_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign out_valid = valid_q;
  assign out_i     = code_q[LANE_I];
  assign out_q     = code_q[LANE_Q];

  // R2: output strobe follows the input strobe by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R9: idle cycles leave the soft outputs untouched
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q)));

  // R6: sign/magnitude carries the input sign in the top bit
  p_sm_sign_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !cfg_twos) |=> (out_i[CODE_W-1] == $past(in_i[DATA_W-1])));

  // R7: two's complement output is negative exactly for negative samples
  p_tc_sign_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && cfg_twos) |=> (out_q[CODE_W-1] == $past(in_q[DATA_W-1])));

endmodule

// File: tb/sim_soft_slicer.sv
module sim_soft_slicer;

  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [9:0] in_i, in_q;
  logic [6:0] cfg_thresh;
  logic       cfg_twos;
  logic       out_valid;
  logic [2:0] out_i, out_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  soft_slicer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_i       (in_i),
    .in_q       (in_q),
    .cfg_thresh (cfg_thresh),
    .cfg_twos   (cfg_twos),
    .out_valid  (out_valid),
    .out_i      (out_i),
    .out_q      (out_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected soft code from the stated rules
  function automatic int expect_code(input int s, input int thr, input bit twos);
    int m, t, lvl;
    bit n;
    n = (s < 0);
    m = n ? -s : s;
    if (m > 511) m = 511;
    t = thr * 4;
    if (m >= 3*t)      lvl = 3;
    else if (m >= 2*t) lvl = 2;
    else if (m >= t)   lvl = 1;
    else               lvl = 0;
    if (!twos) return (n ? 4 : 0) + lvl;
    return n ? ((-(lvl + 1)) & 7) : lvl;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample in, checked one cycle later at the falling edge
  task automatic send(input string req, input int si, input int sq,
                      input int thr, input bit twos);
    @(negedge clk);
    in_i = 10'(si); in_q = 10'(sq);
    cfg_thresh = 7'(thr); cfg_twos = twos; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R2 valid"}, int'(out_valid), 1);
    chk({req, " out_i"}, int'(out_i), expect_code(si, thr, twos));
    chk({req, " out_q"}, int'(out_q), expect_code(sq, thr, twos));
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 out_i in reset", int'(out_i), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", int'(out_valid), 0);
    chk("R1 out_q after release", int'(out_q), 0);
  endtask

  task automatic t_levels_sm();
    // T=80: edges one below and on each threshold, both signs
    send("R3 below T", 79, -79, 20, 0);
    send("R4 on T", 80, -80, 20, 0);
    send("R3 below 2T", 159, -159, 20, 0);
    send("R4 on 2T", 160, -160, 20, 0);
    send("R3 below 3T", 239, -239, 20, 0);
    send("R4 on 3T", 240, -240, 20, 0);
    send("R6 zero and full", 0, 511, 20, 0);
  endtask

  task automatic t_twos();
    send("R7 level0", 79, -79, 20, 1);
    send("R7 level1", 80, -80, 20, 1);
    send("R7 level2", 160, -160, 20, 1);
    send("R7 level3", 511, -511, 20, 1);
    send("R7 minus one", 0, -1, 20, 1);
  endtask

  task automatic t_clamp();
    send("R5 most neg sm", -512, -512, 40, 0);
    send("R5 most neg tc", -512, 511, 40, 1);
  endtask

  task automatic t_wide_thresh();
    send("R8 max thresh", 511, 507, 127, 0);
    send("R8 max thresh neg", -512, -508, 127, 1);
    send("R4 zero thresh", 0, -1, 0, 0);
  endtask

  task automatic t_hold();
    logic [2:0] hi, hq;
    send("R9 seed", 200, -30, 20, 0);
    hi = out_i; hq = out_q;
    @(negedge clk);
    in_i = 10'd5; in_q = 10'd400; cfg_twos = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 valid idle", int'(out_valid), 0);
    chk("R9 out_i held", int'(out_i), int'(hi));
    chk("R9 out_q held", int'(out_q), int'(hq));
  endtask

  task automatic t_independent();
    send("R10 lanes", 300, -10, 25, 0);
    send("R10 lanes swap", -300, 10, 25, 1);
  endtask

  task automatic t_switch();
    @(negedge clk);
    cfg_thresh = 7'd20;
    in_i = 10'(-240); in_q = 10'(100); cfg_twos = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 first valid", int'(out_valid), 1);
    chk("R11 first sm", int'(out_i), expect_code(-240, 20, 0));
    in_i = 10'(-240); in_q = 10'(-100); cfg_twos = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 back to back valid", int'(out_valid), 1);
    chk("R11 second tc", int'(out_i), expect_code(-240, 20, 1));
    chk("R11 second tc q", int'(out_q), expect_code(-100, 20, 1));
    @(negedge clk);
    chk("R2 valid drops", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    cfg_thresh = '0; cfg_twos = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_levels_sm();
    t_twos();
    t_clamp();
    t_wide_thresh();
    t_hold();
    t_independent();
    t_switch();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule